// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

This block watches for a stalled host processor. A counter advances on a slow oscillator tick, one tick per second in the intended use, and it has to be serviced before it reaches a programmable limit. Servicing comes from exactly one of two sources, picked by a configuration bit. One source is a software write of a service bit. The other is a level change, in either direction, on a general-purpose input wired as the service line. A service from the source that is not picked is discarded.

When the limit is reached for the first time, the block issues a primary action. If the host still gives no service for one more full period, it issues a secondary action. Each action is a one-cycle pulse on the device-reset, wake-request or interrupt output. Device resets that the watchdog requests are counted. Once the allowed number of attempts has been used, the next reset request sets a sticky off-hold flag instead, and the counter stops. Only an ON event clears that flag. The watchdog can be paused for debugging and can be gated off during sleep. Writes to its configuration are accepted only while the lock-status input says the registers are unlocked.

Top module: `wdt_escalator`

## Requirements
- R1: After reset the configuration is: enabled, not paused, software service source, sleep gating disabled, timeout code 2, primary action interrupt, secondary action device reset. With no service, an interrupt pulse comes 4 ticks after reset and a device-reset pulse comes 4 ticks after that.
- R2: The timeout field is `wr_data_i[6:5]`. Code n gives a period of 2^n ticks (1, 2, 4 or 8). A timeout pulse appears one clock after the edge that samples the last tick of the period.
- R3: While the pause bit `wr_data_i[1]` is 1, the counter holds its value and no action is issued.
- R4: A write with `wr_data_i[4]`=1 services the watchdog (counter and stage cleared at that edge), but only while the source bit `wr_data_i[2]`, as stored before the write, is 1 (software). Otherwise the write does not service the watchdog.
- R5: While the source bit is 0 (hardware), either edge of `wdi_i` services the watchdog. The input passes a two-flop synchroniser, so the clear takes effect on the third clock edge after the change. While the source bit is 1, edges on `wdi_i` have no effect.
- R6: While `sleep_i` is 1 and the sleep bit `wr_data_i[3]` is 0, the counter holds. With the sleep bit at 1, sleep has no effect and the enable bit alone decides.
- R7: Action codes for primary `wr_data_i[8:7]` and secondary `wr_data_i[10:9]`: 0 device reset, 1 wake request, 2 interrupt, 3 none. The first timeout issues the primary action. The next timeout without service issues the secondary action, and escalation then restarts at primary.
- R8: The enable bit `wr_data_i[0]` at 0 stops the counter. Any write that changes the enable bit clears the counter and the stage. A write that leaves it unchanged does not.
- R9: A primary device reset leaves the next timeout on the primary action. At most 6 device-reset pulses are issued. A further device-reset request raises `off_hold_o` with no pulse and stops the counter.
- R10: A pulse on `on_evt_i` clears `off_hold_o`, the reset-attempt count, the counter and the stage.
- R11: A write while `unlocked_i` is 0 changes no configuration field and causes no service.
- R12: At most one of the three action outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse from the slow oscillator, counted as a timer tick |
| wr_en_i | input | 1 | Configuration write strobe |
| unlocked_i | input | 1 | Lock status; 1 permits writes |
| wr_data_i | input | 11 | Configuration word (fields as in the requirements) |
| wdi_i | input | 1 | Hardware service line, asynchronous |
| sleep_i | input | 1 | System is in sleep |
| on_evt_i | input | 1 | ON event; clears off-hold and the retry count |
| dev_rst_o | output | 1 | Device-reset request pulse |
| wake_o | output | 1 | Wake request pulse |
| irq_o | output | 1 | Interrupt pulse |
| off_hold_o | output | 1 | Sticky off-hold state after retries are exhausted |

## Verification
The assertions assume that every input except `wdi_i` is synchronous to `clk_i`, and that `on_evt_i` and `wr_en_i` are single-cycle strobes; `wdi_i` is sampled only through the synchroniser. The stimulus drives all inputs on the falling edge. Ticks come at a fixed divide or at random, and writes are mostly unlocked with random field values. The random traffic stays within these assumptions. A cycle-level reference model in the bench predicts every output pulse and the off-hold flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int TO_W  = 2;
  localparam int CFG_W = 11;

  // configuration word bit positions
  localparam int B_EN    = 0;
  localparam int B_PAUSE = 1;
  localparam int B_SWSRC = 2;
  localparam int B_SLPEN = 3;
  localparam int B_KICK  = 4;
  localparam int B_TO    = 5;
  localparam int B_PRIM  = 7;
  localparam int B_SEC   = 9;

  typedef enum logic [1:0] {
    ACT_RESET = 2'd0,
    ACT_WAKE  = 2'd1,
    ACT_IRQ   = 2'd2,
    ACT_NONE  = 2'd3
  } wdt_act_e;

  typedef struct packed {
    wdt_act_e            sec;
    wdt_act_e            prim;
    logic [TO_W-1:0]     tmo;
    logic                slp_en;
    logic                sw_src;
    logic                pause;
    logic                en;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RST = '{sec: ACT_RESET, prim: ACT_IRQ, tmo: 2'd2,
                                   slp_en: 1'b0, sw_src: 1'b1, pause: 1'b0, en: 1'b1};
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             unlocked_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output wdt_cfg_t         cfg_o,
  output logic             sw_kick_o,
  output logic             en_flip_o
);
  wdt_cfg_t cfg_q, cfg_d;
  logic     wr_ok;

  always_comb begin
    wr_ok = wr_en_i & unlocked_i;
    cfg_d = cfg_q;
    if (wr_ok) begin
      cfg_d.en     = wr_data_i[B_EN];
      cfg_d.pause  = wr_data_i[B_PAUSE];
      cfg_d.sw_src = wr_data_i[B_SWSRC];
      cfg_d.slp_en = wr_data_i[B_SLPEN];
      cfg_d.tmo    = wr_data_i[B_TO +: TO_W];
      cfg_d.prim   = wdt_act_e'(wr_data_i[B_PRIM +: 2]);
      cfg_d.sec    = wdt_act_e'(wr_data_i[B_SEC +: 2]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  // service uses the source select in effect before this write
  assign sw_kick_o = wr_ok & wr_data_i[B_KICK] & cfg_q.sw_src;
  assign en_flip_o = wr_ok & (wr_data_i[B_EN] != cfg_q.en);
  assign cfg_o     = cfg_q;

  assert_locked_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlocked_i) |=> $stable(cfg_q));

  assert_locked_nokick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |-> !(sw_kick_o || en_flip_o));
endmodule

// File: rtl/wdt_refresh_sync.sv
module wdt_refresh_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  input  logic sw_src_i,
  output logic hw_kick_o
);
  logic [SYNC_N:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[SYNC_N-1:0], wdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  // either edge of the synchronised line, only with hardware source picked
  assign hw_kick_o = (sh_q[SYNC_N] ^ sh_q[SYNC_N-1]) & ~sw_src_i;
endmodule

// File: rtl/wdt_stage_counter.sv
module wdt_stage_counter #(
  parameter int TO_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [TO_W-1:0] tmo_i,
  input  logic            prim_is_reset_i,
  output logic            fire_o,
  output logic            stage_o
);
  localparam int CNT_W = 2 ** TO_W;
  localparam logic [CNT_W-1:0] MAX_LIM = {CNT_W{1'b1}} >> 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             stg_q, stg_d, fire;

  always_comb begin
    lim   = (CNT_W'(1) << tmo_i) - CNT_W'(1);
    cnt_d = cnt_q;
    stg_d = stg_q;
    fire  = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      stg_d = 1'b0;
    end else if (tick_i && run_i) begin
      if (cnt_q >= lim) begin
        cnt_d = '0;
        fire  = 1'b1;
        stg_d = ~stg_q & ~prim_is_reset_i;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stg_q <= stg_d;
    end
  end

  assign fire_o  = fire;
  assign stage_o = stg_q;

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_LIM);

  assert_hold_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !stg_q));
endmodule

// File: rtl/wdt_action_ctl.sv
module wdt_action_ctl
  import wdt_pkg::*;
#(
  parameter int MAX_TRY = 6
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fire_i,
  input  wdt_act_e act_i,
  input  logic     on_evt_i,
  output logic     rst_o,
  output logic     wake_o,
  output logic     irq_o,
  output logic     off_o
);
  localparam int TRY_W = $clog2(MAX_TRY + 1);
  localparam logic [TRY_W-1:0] TRY_LIM = TRY_W'(MAX_TRY);

  logic [TRY_W-1:0] try_q, try_d;
  logic             off_q, off_d;
  logic             rst_q, rst_d, wake_q, wake_d, irq_q, irq_d;
  logic             want_rst, room;

  always_comb begin
    want_rst = fire_i & (act_i == ACT_RESET);
    room     = (try_q < TRY_LIM);
    rst_d    = want_rst & room;
    wake_d   = fire_i & (act_i == ACT_WAKE);
    irq_d    = fire_i & (act_i == ACT_IRQ);
    try_d    = try_q;
    off_d    = off_q;
    if (on_evt_i) begin
      try_d = '0;
      off_d = 1'b0;
    end else if (want_rst) begin
      if (room) try_d = try_q + TRY_W'(1);
      else      off_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      try_q  <= '0;
      off_q  <= 1'b0;
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      try_q  <= try_d;
      off_q  <= off_d;
      rst_q  <= rst_d;
      wake_q <= wake_d;
      irq_q  <= irq_d;
    end
  end

  assign rst_o  = rst_q;
  assign wake_o = wake_q;
  assign irq_o  = irq_q;
  assign off_o  = off_q;

  assert_one_action_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_q, wake_q, irq_q}));

  assert_try_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    try_q <= TRY_LIM);

  assert_off_no_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> !rst_q);

  assert_on_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_evt_i |=> (!off_q && try_q == '0));
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_pkg::*;
#(
  parameter int MAX_TRY = 6,
  parameter int SYNC_N  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             unlocked_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             wdi_i,
  input  logic             sleep_i,
  input  logic             on_evt_i,
  output logic             dev_rst_o,
  output logic             wake_o,
  output logic             irq_o,
  output logic             off_hold_o
);
  logic [1:0] rs_q;
  logic       rst_n;
  wdt_cfg_t   cfg;
  logic       sw_kick, en_flip, hw_kick, clr, run, fire, stage, off;
  wdt_act_e   act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  wdt_cfg_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_en_i(wr_en_i), .unlocked_i(unlocked_i),
    .wr_data_i(wr_data_i), .cfg_o(cfg), .sw_kick_o(sw_kick), .en_flip_o(en_flip)
  );

  wdt_refresh_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .wdi_i(wdi_i), .sw_src_i(cfg.sw_src),
    .hw_kick_o(hw_kick)
  );

  always_comb begin
    clr = sw_kick | hw_kick | en_flip | on_evt_i;
    run = cfg.en & ~(sleep_i & ~cfg.slp_en) & ~cfg.pause & ~off;
    act = stage ? cfg.sec : cfg.prim;
  end

  wdt_stage_counter #(.TO_W(TO_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick_i), .run_i(run), .clr_i(clr),
    .tmo_i(cfg.tmo), .prim_is_reset_i(cfg.prim == ACT_RESET),
    .fire_o(fire), .stage_o(stage)
  );

  wdt_action_ctl #(.MAX_TRY(MAX_TRY)) u_act (
    .clk_i(clk_i), .rst_ni(rst_n), .fire_i(fire), .act_i(act), .on_evt_i(on_evt_i),
    .rst_o(dev_rst_o), .wake_o(wake_o), .irq_o(irq_o), .off_o(off)
  );

  assign off_hold_o = off;

  assert_off_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    off |-> !fire);
endmodule

// File: tb/wdt_escalator_tb_top.sv
module wdt_escalator_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, unlocked_i = 1'b0;
  logic [10:0] wr_data_i = '0;
  logic        wdi_i = 1'b0, sleep_i = 1'b0, on_evt_i = 1'b0;
  logic        dev_rst_o, wake_o, irq_o, off_hold_o;

  int    tests = 0, fails = 0, cyc = 0;
  int    n_rst = 0, n_wake = 0, n_irq = 0;
  bit    rand_tick = 1'b0, done = 1'b0;
  string req = "R1";

  always #5 clk = ~clk;

  wdt_escalator dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .unlocked_i(unlocked_i), .wr_data_i(wr_data_i), .wdi_i(wdi_i),
    .sleep_i(sleep_i), .on_evt_i(on_evt_i), .dev_rst_o(dev_rst_o),
    .wake_o(wake_o), .irq_o(irq_o), .off_hold_o(off_hold_o)
  );

  // ---------------- reference model ----------------
  logic [1:0] m_rs;
  logic       m_en, m_pause, m_sw, m_slp, m_stg, m_off;
  logic [1:0] m_to, m_pa, m_sa;
  int         m_cnt, m_try;
  logic [2:0] m_s;
  logic       e_rst, e_wake, e_irq;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) m_rs <= 2'b00;
    else         m_rs <= {m_rs[0], 1'b1};
    if (!rst_ni || !m_rs[1]) begin
      m_en <= 1; m_pause <= 0; m_sw <= 1; m_slp <= 0; m_to <= 2; m_pa <= 2; m_sa <= 0;
      m_cnt <= 0; m_stg <= 0; m_try <= 0; m_off <= 0; m_s <= 0;
      e_rst <= 0; e_wake <= 0; e_irq <= 0;
    end else begin
      automatic bit wr_ok = wr_en_i && unlocked_i;
      automatic bit clr = (wr_ok && wr_data_i[4] && m_sw) || (wr_ok && wr_data_i[0] != m_en)
                          || ((m_s[2] ^ m_s[1]) && !m_sw) || on_evt_i;
      automatic bit run = m_en && !(sleep_i && !m_slp) && !m_pause && !m_off;
      automatic int lim = (1 << m_to) - 1;
      automatic bit fire = 0;
      automatic logic [1:0] act = m_stg ? m_sa : m_pa;
      if (clr) begin m_cnt <= 0; m_stg <= 0; end
      else if (tick_i && run) begin
        if (m_cnt >= lim) begin
          m_cnt <= 0; fire = 1; m_stg <= !m_stg && (m_pa != 0);
        end else m_cnt <= m_cnt + 1;
      end
      e_rst  <= fire && act == 0 && m_try < 6;
      e_wake <= fire && act == 1;
      e_irq  <= fire && act == 2;
      if (on_evt_i) begin m_try <= 0; m_off <= 0; end
      else if (fire && act == 0) begin
        if (m_try < 6) m_try <= m_try + 1; else m_off <= 1;
      end
      if (wr_ok) begin
        m_en <= wr_data_i[0]; m_pause <= wr_data_i[1]; m_sw <= wr_data_i[2];
        m_slp <= wr_data_i[3]; m_to <= wr_data_i[6:5]; m_pa <= wr_data_i[8:7];
        m_sa <= wr_data_i[10:9];
      end
      m_s <= {m_s[1:0], wdi_i};
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (m_rs[1] && !done) begin
      chk({dev_rst_o, wake_o, irq_o, off_hold_o} == {e_rst, e_wake, e_irq, m_off}, req,
          {dev_rst_o, wake_o, irq_o, off_hold_o}, {e_rst, e_wake, e_irq, m_off});
      chk($countones({dev_rst_o, wake_o, irq_o}) <= 1, "R12",
          $countones({dev_rst_o, wake_o, irq_o}), 1);
      n_rst += int'(dev_rst_o); n_wake += int'(wake_o); n_irq += int'(irq_o);
    end
  end

  // tick source: one pulse every 4 cycles, or random
  always @(negedge clk) tick_i <= rand_tick ? ($urandom % 3 == 0) : (cyc % 4 == 0);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [10:0] cfgw(bit en, bit ps, bit sw, bit slp, logic [1:0] to,
                                       logic [1:0] pa, logic [1:0] sa, bit kick);
    return {sa, pa, to, kick, slp, sw, ps, en};
  endfunction

  task automatic wr(input logic [10:0] d, input bit unl);
    @(negedge clk);
    wr_en_i = 1; wr_data_i = d; unlocked_i = unl;
    @(negedge clk);
    wr_en_i = 0; unlocked_i = 0;
  endtask

  task automatic clr_counts();
    n_rst = 0; n_wake = 0; n_irq = 0;
  endtask

  task automatic on_pulse();
    @(negedge clk); on_evt_i = 1;
    @(negedge clk); on_evt_i = 0;
  endtask

  initial begin
    void'($urandom(32'h1d0c5eed));
    repeat (4) @(negedge clk);
    rst_ni = 1;
    step(3);
    chk({dev_rst_o, wake_o, irq_o, off_hold_o} == 4'b0, "R1", {dev_rst_o, wake_o, irq_o, off_hold_o}, 0);

    // R1: defaults, interrupt then device reset
    req = "R1"; clr_counts(); step(40);
    chk(n_irq == 1, "R1", n_irq, 1);
    chk(n_rst == 1, "R1", n_rst, 1);
    on_pulse();

    // R2 / R7: each timeout code, wake then none
    for (int t = 0; t < 4; t++) begin
      req = "R2";
      wr(cfgw(1, 0, 1, 0, t[1:0], 2'd1, 2'd3, 1), 1); clr_counts();
      step(4 * (1 << t) * 4 + 8);
      chk(n_wake >= 1, "R7", n_wake, 1);
    end

    // R3: pause
    req = "R3"; wr(cfgw(1, 1, 1, 0, 2'd0, 2'd2, 2'd2, 1), 1); clr_counts(); step(60);
    chk(n_irq == 0, "R3", n_irq, 0);
    wr(cfgw(1, 0, 1, 0, 2'd0, 2'd2, 2'd2, 0), 1); step(20);

    // R4: software service keeps it quiet; ignored with hardware source
    req = "R4"; wr(cfgw(1, 0, 1, 0, 2'd2, 2'd2, 2'd1, 1), 1); clr_counts();
    for (int i = 0; i < 8; i++) begin wr(cfgw(1, 0, 1, 0, 2'd2, 2'd2, 2'd1, 1), 1); step(6); end
    chk(n_irq + n_wake == 0, "R4", n_irq + n_wake, 0);
    wr(cfgw(1, 0, 0, 0, 2'd2, 2'd2, 2'd1, 0), 1); clr_counts();
    for (int i = 0; i < 8; i++) begin wr(cfgw(1, 0, 0, 0, 2'd2, 2'd2, 2'd1, 1), 1); step(6); end
    chk(n_irq >= 1, "R4", n_irq, 1);

    // R5: hardware toggles keep it quiet; ignored with software source
    req = "R5"; clr_counts();
    for (int i = 0; i < 10; i++) begin @(negedge clk); wdi_i = ~wdi_i; step(7); end
    chk(n_irq + n_wake == 0, "R5", n_irq + n_wake, 0);
    wr(cfgw(1, 0, 1, 0, 2'd2, 2'd2, 2'd1, 0), 1); clr_counts();
    for (int i = 0; i < 10; i++) begin @(negedge clk); wdi_i = ~wdi_i; step(7); end
    chk(n_irq >= 1, "R5", n_irq, 1);

    // R6: sleep gating
    req = "R6"; wr(cfgw(1, 0, 1, 0, 2'd0, 2'd2, 2'd2, 1), 1);
    sleep_i = 1; clr_counts(); step(40);
    chk(n_irq == 0, "R6", n_irq, 0);
    wr(cfgw(1, 0, 1, 1, 2'd0, 2'd2, 2'd2, 0), 1); clr_counts(); step(40);
    chk(n_irq >= 1, "R6", n_irq, 1);
    sleep_i = 0;

    // R8: enable off, then on clears counter
    req = "R8"; wr(cfgw(0, 0, 1, 0, 2'd1, 2'd2, 2'd2, 0), 1); clr_counts(); step(50);
    chk(n_irq == 0, "R8", n_irq, 0);
    wr(cfgw(1, 0, 1, 0, 2'd1, 2'd2, 2'd2, 0), 1); step(40);

    // R11: locked write of enable=0 ignored
    req = "R11"; wr(cfgw(0, 1, 1, 0, 2'd0, 2'd3, 2'd3, 1), 0); clr_counts(); step(40);
    chk(n_irq >= 1, "R11", n_irq, 1);

    // R9: primary reset, retry limit
    req = "R9"; on_pulse(); wr(cfgw(1, 0, 1, 0, 2'd0, 2'd0, 2'd2, 1), 1); clr_counts(); step(60);
    chk(n_rst == 6, "R9", n_rst, 6);
    chk(n_irq == 0, "R9", n_irq, 0);
    chk(off_hold_o == 1, "R9", off_hold_o, 1);

    // R10: ON event releases the hold
    req = "R10"; on_pulse(); step(1);
    chk(off_hold_o == 0, "R10", off_hold_o, 0);
    clr_counts(); step(12);
    chk(n_rst >= 1, "R10", n_rst, 1);

    // random traffic checked against the model
    req = "R12"; rand_tick = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en_i = ($urandom % 9 == 0); unlocked_i = ($urandom % 5 != 0);
      wr_data_i = 11'($urandom) | 11'h001;
      if ($urandom % 4 == 0) wdi_i = ~wdi_i;
      if ($urandom % 16 == 0) sleep_i = ~sleep_i;
      on_evt_i = ($urandom % 150 == 0);
    end
    @(negedge clk); wr_en_i = 0; on_evt_i = 0; step(10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule